// File: doc/BRIEF.md
# Byte-wide NOR flash command controller

This block is a synthesizable behavioural model of the command side of a byte-wide parallel NOR flash. A host drives an asynchronous-style bus of chip enable, write enable and output enable, all sampled on the model's clock. Write cycles are decoded into unlock-protected command sequences. These sequences start timed byte programs, single-sector erases or whole-array erases on a small register-built array. Erases can be suspended and resumed.

While an operation runs, reads return a status byte instead of array data. The status byte carries a data-polling bit, a bit that toggles on every read, and a second toggle bit that moves only for sectors picked for erase. A hardware protect mask, one bit per sector, keeps chosen sectors out of reach of both program and erase. The array holds 2^ADDR_W bytes in eight equal sectors, and the top three address bits pick the sector.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, every byte reads FFh and no operation is running, so reads return array data.
- R2: The writes AAh@155h, 55h@0AAh and A0h@155h, followed by a write of data D to address X, program byte X. After PROG_CYC cycles, X holds its old value ANDed with D. Unlock addresses are the low ADDR_W bits of 555h and 2AAh.
- R3: A write that does not fit the sequence in progress returns the decoder to read mode, and that write is discarded. This includes F0h and wrong unlock data or addresses.
- R4: While a program is running, a read returns a status byte. Bit 7 is the complement of bit 7 of the programmed data. Bit 6 flips after every completed read. All other bits are 0. Once the program finishes, reads return array data.
- R5: The writes AAh@155h, 55h@0AAh, 80h@155h, AAh@155h and 55h@0AAh, followed by 30h at any address, erase that address's sector. The sector first goes to all zeros and, ERASE_CYC cycles after the command, to all ones. Status during the erase has bit 7 = 0 and bit 6 flipping per read. Other sectors keep their contents.
- R6: The same erase prefix followed by 10h@155h erases every unprotected sector.
- R7: Program or erase aimed at a sector whose protect bit is 1 does nothing and starts no operation. A chip erase skips protected sectors.
- R8: During an erase or an erase suspend, status bit 2 flips after each read of an address in a sector picked for erase. It holds its value for reads of other sectors.
- R9: A write of B0h during an erase suspends it and freezes its timer. While suspended, reads of unpicked sectors return data, and reads of picked sectors return status with bit 6 steady. A program to an unpicked sector runs and then returns to the suspend. A program to a picked sector is ignored. A write of 30h resumes the erase for its remaining time.
- R10: While a program or an unsuspended erase runs, every write other than B0h during an erase is ignored.
- R11: dout_en is 1 and dout is driven only when ce_n and oe_n are both 0; otherwise dout is 0. A write is taken when we_n rises while ce_n is 0; writes with ce_n high are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock; bus pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; its rising edge latches a write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address; top three bits select the sector |
| din | input | 8 | Write data / command byte |
| prot | input | 8 | Per-sector protect mask, 1 = protected |
| dout | output | 8 | Read data or status byte |
| dout_en | output | 1 | High while the read path drives dout |

## Verification
The hardest state to reach is a program running inside a suspended erase. To get there, the bench must first start a sector erase, issue the suspend before the erase timer expires, and then fit a full unlock-and-program sequence into the suspend. After that it must check three things: the frozen erase neither progressed nor completed, the program into the unpicked sector landed, and the resumed erase still finished on time. The stimulus interleaves these writes with paired reads on picked and unpicked sectors. Every clock is compared against a behavioural reference that tracks remaining time and toggle state, so a one-cycle slip in the frozen timer or a wrong toggle shows up at once.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int SECT_BITS = 3;
    localparam int NUM_SECT  = 1 << SECT_BITS;

    localparam logic [7:0] K_UNL1   = 8'hAA;
    localparam logic [7:0] K_UNL2   = 8'h55;
    localparam logic [7:0] K_PGM    = 8'hA0;
    localparam logic [7:0] K_ERS    = 8'h80;
    localparam logic [7:0] K_SECT   = 8'h30;
    localparam logic [7:0] K_CHIP   = 8'h10;
    localparam logic [7:0] K_SUSP   = 8'hB0;
    localparam logic [7:0] K_RESUME = 8'h30;

    localparam logic [15:0] UNL_ADDR1 = 16'h0555;
    localparam logic [15:0] UNL_ADDR2 = 16'h02AA;

    typedef enum logic [2:0] {
        OP_IDLE, OP_PGM, OP_ERS, OP_SUSP, OP_SPGM
    } op_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3
    } seq_e;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_PGM, CMD_SERASE, CMD_CERASE, CMD_SUSP, CMD_RESUME
    } cmd_e;

    typedef struct packed {
        logic poll;
        logic tog;
        logic tog2;
    } status_t;

    function automatic logic [7:0] pack_status(input status_t s);
        return {s.poll, s.tog, 3'b000, s.tog2, 2'b00};
    endfunction

    function automatic logic op_running(input op_e op);
        return (op == OP_PGM) || (op == OP_ERS) || (op == OP_SPGM);
    endfunction

endpackage

// File: rtl/fcmd_seq.sv
module fcmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  op_e               op,
    output cmd_e              cmd
);
    localparam logic [ADDR_W-1:0] UA1 = UNL_ADDR1[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] UA2 = UNL_ADDR2[ADDR_W-1:0];

    seq_e seq, seq_n;
    logic at1, at2;

    assign at1 = (waddr == UA1);
    assign at2 = (waddr == UA2);

    always_comb begin
        seq_n = seq;
        cmd   = CMD_NONE;
        if (op_running(op)) begin
            seq_n = SQ_IDLE;
            if (wr_evt && op == OP_ERS && wdata == K_SUSP) cmd = CMD_SUSP;
        end else if (wr_evt) begin
            seq_n = SQ_IDLE;
            unique case (seq)
                SQ_IDLE: begin
                    if (wdata == K_UNL1 && at1) seq_n = SQ_U1;
                    else if (op == OP_SUSP && wdata == K_RESUME) cmd = CMD_RESUME;
                end
                SQ_U1: if (wdata == K_UNL2 && at2) seq_n = SQ_U2;
                SQ_U2: begin
                    if (wdata == K_PGM && at1) seq_n = SQ_PGM;
                    else if (wdata == K_ERS && at1 && op == OP_IDLE) seq_n = SQ_E1;
                end
                SQ_PGM: cmd = CMD_PGM;
                SQ_E1: if (wdata == K_UNL1 && at1) seq_n = SQ_E2;
                SQ_E2: if (wdata == K_UNL2 && at2) seq_n = SQ_E3;
                SQ_E3: begin
                    if (wdata == K_SECT) cmd = CMD_SERASE;
                    else if (wdata == K_CHIP && at1) cmd = CMD_CERASE;
                end
                default: seq_n = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq <= SQ_IDLE;
        else     seq <= seq_n;
    end

    AST_BUSY_SEQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (op_running(op) && op_running($past(op))) |-> (seq == SQ_IDLE)) // R10
        else $error("decoder left idle during a running operation");

endmodule

// File: rtl/fcmd_engine.sv
module fcmd_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int PROG_CYC  = 16,
    parameter int PRE_CYC   = 8,
    parameter int ERASE_CYC = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  cmd_e                cmd,
    input  logic [ADDR_W-1:0]   waddr,
    input  logic [7:0]          wdata,
    input  logic [NUM_SECT-1:0] prot,
    output op_e                 op,
    output logic [ADDR_W-1:0]   pa,
    output logic [7:0]          pd,
    output logic [NUM_SECT-1:0] mask,
    output logic                pgm_fire,
    output logic                pre_fire,
    output logic                ers_fire
);
    localparam int PCW = $clog2(PROG_CYC) + 1;
    localparam int ECW = $clog2(ERASE_CYC) + 1;
    localparam logic [PCW-1:0] P_LAST  = PCW'(PROG_CYC - 1);
    localparam logic [ECW-1:0] PR_LAST = ECW'(PRE_CYC - 1);
    localparam logic [ECW-1:0] E_LAST  = ECW'(ERASE_CYC - 1);

    logic [PCW-1:0]      pcnt;
    logic [ECW-1:0]      ecnt;
    logic [SECT_BITS-1:0] wsec;
    logic [NUM_SECT-1:0] sel_one, sel_all;
    logic                pgm_ok;

    assign wsec    = waddr[ADDR_W-1 -: SECT_BITS];
    assign sel_one = (NUM_SECT'(1) << wsec) & ~prot;
    assign sel_all = ~prot;
    assign pgm_ok  = !prot[wsec];

    assign pgm_fire = (op == OP_PGM || op == OP_SPGM) && pcnt == P_LAST;
    assign pre_fire = (op == OP_ERS) && cmd != CMD_SUSP && ecnt == PR_LAST;
    assign ers_fire = (op == OP_ERS) && cmd != CMD_SUSP && ecnt == E_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            op   <= OP_IDLE;
            pa   <= '0;
            pd   <= '0;
            mask <= '0;
            pcnt <= '0;
            ecnt <= '0;
        end else begin
            unique case (op)
                OP_IDLE: begin
                    if (cmd == CMD_PGM && pgm_ok) begin
                        op <= OP_PGM; pa <= waddr; pd <= wdata; pcnt <= '0;
                    end else if (cmd == CMD_SERASE && |sel_one) begin
                        op <= OP_ERS; mask <= sel_one; ecnt <= '0;
                    end else if (cmd == CMD_CERASE && |sel_all) begin
                        op <= OP_ERS; mask <= sel_all; ecnt <= '0;
                    end
                end
                OP_PGM, OP_SPGM: begin
                    if (pcnt == P_LAST) op <= (op == OP_PGM) ? OP_IDLE : OP_SUSP;
                    else                pcnt <= pcnt + 1'b1;
                end
                OP_ERS: begin
                    if (cmd == CMD_SUSP)     op <= OP_SUSP;
                    else if (ecnt == E_LAST) begin op <= OP_IDLE; mask <= '0; end
                    else                     ecnt <= ecnt + 1'b1;
                end
                OP_SUSP: begin
                    if (cmd == CMD_RESUME) op <= OP_ERS;
                    else if (cmd == CMD_PGM && pgm_ok && !mask[wsec]) begin
                        op <= OP_SPGM; pa <= waddr; pd <= wdata; pcnt <= '0;
                    end
                end
                default: op <= OP_IDLE;
            endcase
        end
    end

    AST_PGM_UNPROT: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_PGM || op == OP_SPGM) && !($past(op) == OP_PGM || $past(op) == OP_SPGM))
        |-> !$past(prot[pa[ADDR_W-1 -: SECT_BITS]])) // R7
        else $error("program started in a protected sector");

    AST_ERS_UNPROT: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ERS && $past(op) == OP_IDLE) |-> ((mask & $past(prot)) == '0 && mask != '0)) // R7
        else $error("erase picked a protected sector");

    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SUSP) |=> (op != OP_IDLE && op != OP_PGM)) // R9
        else $error("suspended erase ended without resume");

    AST_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SUSP || op == OP_SPGM) |-> $stable(mask)) // R9
        else $error("erase selection changed during suspend");

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pgm_fire,
    input  logic [ADDR_W-1:0]   pa,
    input  logic [7:0]          pd,
    input  logic                pre_fire,
    input  logic                ers_fire,
    input  logic [NUM_SECT-1:0] mask,
    input  logic [ADDR_W-1:0]   raddr,
    output logic [7:0]          rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    assign rdata = mem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (pgm_fire) begin
            mem[pa] <= mem[pa] & pd;
        end else if (pre_fire || ers_fire) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (mask[ADDR_W'(i) >> (ADDR_W - SECT_BITS)])
                    mem[i] <= ers_fire ? 8'hFF : 8'h00;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 9,
    parameter int PROG_CYC  = 16,
    parameter int PRE_CYC   = 8,
    parameter int ERASE_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic [7:0]        prot,
    output logic [7:0]        dout,
    output logic              dout_en
);
    logic                we_q, rd_q, rd_now, rd_end, wr_evt;
    logic                tog6, tog2;
    cmd_e                cmd;
    op_e                 op;
    logic [ADDR_W-1:0]   pa;
    logic [7:0]          pd, rdata, rd_val;
    logic [NUM_SECT-1:0] mask;
    logic                pgm_fire, pre_fire, ers_fire;
    logic [SECT_BITS-1:0] rsec;
    status_t             sts;

    assign rd_now = !ce_n && !oe_n;
    assign rd_end = rd_q && !rd_now;
    assign wr_evt = !we_q && we_n && !ce_n;
    assign rsec   = addr[ADDR_W-1 -: SECT_BITS];

    always_ff @(posedge clk) begin
        if (rst) begin
            we_q <= 1'b1;
            rd_q <= 1'b0;
            tog6 <= 1'b0;
            tog2 <= 1'b0;
        end else begin
            we_q <= we_n;
            rd_q <= rd_now;
            if (rd_end && op_running(op)) tog6 <= ~tog6;
            if (rd_end && (op == OP_ERS || op == OP_SUSP) && mask[rsec]) tog2 <= ~tog2;
        end
    end

    fcmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .wr_evt(wr_evt), .waddr(addr), .wdata(din),
        .op(op), .cmd(cmd)
    );

    fcmd_engine #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC), .PRE_CYC(PRE_CYC),
                  .ERASE_CYC(ERASE_CYC)) u_engine (
        .clk(clk), .rst(rst), .cmd(cmd), .waddr(addr), .wdata(din), .prot(prot),
        .op(op), .pa(pa), .pd(pd), .mask(mask),
        .pgm_fire(pgm_fire), .pre_fire(pre_fire), .ers_fire(ers_fire)
    );

    fcmd_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst(rst), .pgm_fire(pgm_fire), .pa(pa), .pd(pd),
        .pre_fire(pre_fire), .ers_fire(ers_fire), .mask(mask),
        .raddr(addr), .rdata(rdata)
    );

    always_comb begin
        sts    = '{poll: 1'b0, tog: tog6, tog2: tog2};
        rd_val = rdata;
        unique case (op)
            OP_PGM, OP_SPGM: begin
                sts.poll = ~pd[7];
                sts.tog2 = 1'b0;
                rd_val   = pack_status(sts);
            end
            OP_ERS:  rd_val = pack_status(sts);
            OP_SUSP: rd_val = mask[rsec] ? pack_status(sts) : rdata;
            default: rd_val = rdata;
        endcase
    end

    assign dout_en = rd_now;
    assign dout    = rd_now ? rd_val : 8'h00;

    AST_STATUS_STEADY: assert property (@(posedge clk) disable iff (rst)
        (rd_now && rd_q && $stable(op) && op_running(op) && $stable(addr)) |-> $stable(dout)) // R4
        else $error("status byte changed inside one read");

    AST_TOGGLE_RUNNING: assert property (@(posedge clk) disable iff (rst)
        (tog6 != $past(tog6)) |-> op_running($past(op))) // R9
        else $error("toggle bit moved while no operation ran");

endmodule

// File: tb/flash_cmd_fsm_bench.sv
module flash_cmd_fsm_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 9;
    localparam int PGMC = 16;
    localparam int PREC = 8;
    localparam int ERSC = 64;

    logic clk = 0, rst = 1;
    logic ce_n = 1, we_n = 1, oe_n = 1;
    logic [AW-1:0] addr = '0;
    logic [7:0] din = '0, prot = '0;
    logic [7:0] dout;
    logic dout_en;

    int checks = 0, failures = 0;
    string ctx = "R1";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_fsm #(.ADDR_W(AW), .PROG_CYC(PGMC), .PRE_CYC(PREC), .ERASE_CYC(ERSC)) u_flash_cmd_fsm (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .prot(prot), .dout(dout), .dout_en(dout_en)
    );

    // reference model: 0 idle, 1 program, 2 erase, 3 suspended, 4 program in suspend
    logic [7:0] mm [512];
    int mop, mseq, mpc, mec;
    logic [AW-1:0] mpa;
    logic [7:0] mpd, mmask;
    logic mt6, mt2, mweq, mrdq;

    always @(posedge clk) begin : model
        logic wr, rd, rdend;
        int op0, cmd, ns;
        logic [2:0] ws;
        logic [7:0] m;
        if (rst) begin
            for (int i = 0; i < 512; i++) mm[i] = 8'hFF;
            mop = 0; mseq = 0; mpc = 0; mec = 0; mpa = '0; mpd = '0; mmask = '0;
            mt6 = 0; mt2 = 0; mweq = 1; mrdq = 0;
        end else begin
            wr = !mweq && we_n && !ce_n;
            rd = !ce_n && !oe_n;
            rdend = mrdq && !rd;
            op0 = mop; ws = addr[8:6]; cmd = 0;
            if (rdend) begin
                if (op0 == 1 || op0 == 2 || op0 == 4) mt6 = ~mt6;
                if ((op0 == 2 || op0 == 3) && mmask[ws]) mt2 = ~mt2;
            end
            if (op0 == 1 || op0 == 2 || op0 == 4) begin
                mseq = 0;
                if (wr && op0 == 2 && din == 8'hB0) cmd = 4;
            end else if (wr) begin
                ns = 0;
                case (mseq)
                    0: if (din == 8'hAA && addr == 9'h155) ns = 1;
                       else if (op0 == 3 && din == 8'h30) cmd = 5;
                    1: if (din == 8'h55 && addr == 9'h0AA) ns = 2;
                    2: if (din == 8'hA0 && addr == 9'h155) ns = 3;
                       else if (din == 8'h80 && addr == 9'h155 && op0 == 0) ns = 4;
                    3: cmd = 1;
                    4: if (din == 8'hAA && addr == 9'h155) ns = 5;
                    5: if (din == 8'h55 && addr == 9'h0AA) ns = 6;
                    6: if (din == 8'h30) cmd = 2;
                       else if (din == 8'h10 && addr == 9'h155) cmd = 3;
                    default: ns = 0;
                endcase
                mseq = ns;
            end
            case (op0)
                0: begin
                    if (cmd == 1 && !prot[ws]) begin mop = 1; mpa = addr; mpd = din; mpc = 0; end
                    else if (cmd == 2 || cmd == 3) begin
                        m = (cmd == 2) ? ((8'h1 << ws) & ~prot) : ~prot;
                        if (m != 0) begin mop = 2; mmask = m; mec = 0; end
                    end
                end
                1, 4: begin
                    if (mpc == PGMC - 1) begin mm[mpa] = mm[mpa] & mpd; mop = (op0 == 1) ? 0 : 3; end
                    else mpc++;
                end
                2: begin
                    if (cmd == 4) mop = 3;
                    else begin
                        if (mec == PREC - 1)
                            for (int i = 0; i < 512; i++) if (mmask[i >> 6]) mm[i] = 8'h00;
                        if (mec == ERSC - 1) begin
                            for (int i = 0; i < 512; i++) if (mmask[i >> 6]) mm[i] = 8'hFF;
                            mop = 0; mmask = 0;
                        end else mec++;
                    end
                end
                3: begin
                    if (cmd == 5) mop = 2;
                    else if (cmd == 1 && !prot[ws] && !mmask[ws]) begin
                        mop = 4; mpa = addr; mpd = din; mpc = 0;
                    end
                end
                default: mop = 0;
            endcase
            mweq = we_n;
            mrdq = rd;
        end
    end

    function automatic logic [7:0] exp_dout();
        logic [2:0] s;
        if (ce_n || oe_n) return 8'h00;
        s = addr[8:6];
        case (mop)
            1, 4: return {~mpd[7], mt6, 6'b0};
            2:    return {1'b0, mt6, 3'b0, mt2, 2'b0};
            3:    return mmask[s] ? {1'b0, mt6, 3'b0, mt2, 2'b0} : mm[addr];
            default: return mm[addr];
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h exp=%02h t=%0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R11 for the enable, ctx for data)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R11", {7'b0, dout_en}, {7'b0, (!ce_n && !oe_n)});
            chk(ctx, dout, exp_dout());
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(posedge clk); #1 ce_n = 0; we_n = 0; addr = a; din = d;
        @(posedge clk); #1 we_n = 1;
        @(posedge clk); #1 ce_n = 1;
    endtask

    task automatic wr_noce(input logic [AW-1:0] a, input logic [7:0] d);
        @(posedge clk); #1 we_n = 0; addr = a; din = d;
        @(posedge clk); #1 we_n = 1;
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(posedge clk); #1 ce_n = 0; oe_n = 0; addr = a;
        @(negedge clk); v = dout;
        @(posedge clk); #1 ce_n = 1; oe_n = 1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pgm(input logic [AW-1:0] a, input logic [7:0] d);
        wr(9'h155, 8'hAA); wr(9'h0AA, 8'h55); wr(9'h155, 8'hA0); wr(a, d);
    endtask

    task automatic ers(input logic [AW-1:0] a, input logic [7:0] c);
        wr(9'h155, 8'hAA); wr(9'h0AA, 8'h55); wr(9'h155, 8'h80);
        wr(9'h155, 8'hAA); wr(9'h0AA, 8'h55); wr(a, c);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v, v2;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        ctx = "R1";
        rd(9'h000, v); chk("R1", v, 8'hFF);
        rd(9'h1FF, v); chk("R1", v, 8'hFF);

        ctx = "R11";
        @(posedge clk); #1 ce_n = 0; oe_n = 1; addr = 9'h000;
        @(negedge clk); chk("R11", {7'b0, dout_en}, 8'h00); chk("R11", dout, 8'h00);
        @(posedge clk); #1 ce_n = 1;
        wr_noce(9'h155, 8'hAA); wr_noce(9'h0AA, 8'h55); wr_noce(9'h155, 8'hA0); wr_noce(9'h043, 8'h00);
        idle(PGMC + 4);
        rd(9'h043, v); chk("R11", v, 8'hFF);

        ctx = "R4";
        pgm(9'h040, 8'h5A);
        rd(9'h040, v); rd(9'h040, v2);
        chk("R4", v & 8'h80, 8'h80);
        chk("R4", v ^ v2, 8'h40);
        idle(PGMC + 4);
        ctx = "R2";
        rd(9'h040, v); chk("R2", v, 8'h5A);
        pgm(9'h040, 8'h0F); idle(PGMC + 4);
        rd(9'h040, v); chk("R2", v, 8'h0A);

        ctx = "R3";
        wr(9'h155, 8'hAA); wr(9'h0AA, 8'h12); wr(9'h155, 8'hA0); wr(9'h040, 8'h00);
        idle(PGMC + 4);
        rd(9'h040, v); chk("R3", v, 8'h0A);
        wr(9'h155, 8'hAA); wr(9'h0AA, 8'h55); wr(9'h155, 8'hF0); wr(9'h040, 8'h00);
        idle(PGMC + 4);
        rd(9'h040, v); chk("R3", v, 8'h0A);

        ctx = "R7";
        prot = 8'h80;
        pgm(9'h1C0, 8'h00);
        rd(9'h1C0, v); chk("R7", v, 8'hFF);
        idle(PGMC + 4);
        rd(9'h1C0, v); chk("R7", v, 8'hFF);
        ers(9'h1C0, 8'h30);
        rd(9'h1C1, v); chk("R7", v, 8'hFF);

        ctx = "R5";
        pgm(9'h080, 8'h33); idle(PGMC + 4);
        ers(9'h080, 8'h30);
        rd(9'h080, v); rd(9'h080, v2);
        chk("R5", v & 8'h80, 8'h00);
        chk("R8", v ^ v2, 8'h44);
        rd(9'h040, v); rd(9'h040, v2);
        chk("R8", v ^ v2, 8'h40);
        ctx = "R10";
        pgm(9'h042, 8'h00);
        idle(ERSC + 4);
        ctx = "R5";
        rd(9'h080, v); chk("R5", v, 8'hFF);
        rd(9'h040, v); chk("R5", v, 8'h0A);
        rd(9'h042, v); chk("R10", v, 8'hFF);

        ctx = "R9";
        pgm(9'h0C0, 8'h11); idle(PGMC + 4);
        ers(9'h0C0, 8'h30);
        idle(5);
        wr(9'h000, 8'hB0);
        idle(ERSC + 20);
        rd(9'h040, v); chk("R9", v, 8'h0A);
        rd(9'h0C0, v); rd(9'h0C0, v2);
        chk("R9", v ^ v2, 8'h04);
        pgm(9'h041, 8'h3C); idle(PGMC + 4);
        rd(9'h041, v); chk("R9", v, 8'h3C);
        pgm(9'h0C1, 8'h00); idle(PGMC + 4);
        rd(9'h0C1, v); chk("R9", v & 8'h80, 8'h00);
        wr(9'h000, 8'h30);
        rd(9'h0C5, v); chk("R9", v & 8'hBB, 8'h00);
        idle(ERSC + 4);
        rd(9'h0C0, v); chk("R9", v, 8'hFF);
        rd(9'h0C1, v); chk("R9", v, 8'hFF);
        rd(9'h041, v); chk("R9", v, 8'h3C);

        ctx = "R6";
        prot = 8'h00;
        pgm(9'h1C0, 8'h00); idle(PGMC + 4);
        prot = 8'h80;
        ers(9'h155, 8'h10);
        idle(ERSC + 4);
        rd(9'h041, v); chk("R6", v, 8'hFF);
        rd(9'h040, v); chk("R6", v, 8'hFF);
        rd(9'h1C0, v); chk("R7", v, 8'h00);

        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule